// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital mode sequencer of a LIN physical-layer interface. It tracks four operating modes: Unpowered, Fail-safe, Normal and Sleep. From these it drives the enable of the external regulator-inhibit switch, the transmit-path and receive-path enables, the level presented on the receive-data output, and the two pull-down controls on the transmit-data pin that report where a wake-up came from. Analog conditions reach the block as digital inputs only: a supply-good indication, a received bus level, and already-filtered wake pulses from a bus detector and a local detector.

The enable pin is asynchronous and passes through a two-flop synchronizer. Changes of mode requested through the enable pin are debounced by counting a one-microsecond tick. A mode change happens only when the synchronized enable has held its new level for a whole delay. When the enable is raised, any latched wake indication is cleared at once, before Normal mode is reached.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While the asynchronous active-low reset is asserted, the block is in Unpowered: inh_on, tx_path_en, rx_path_en, txd_strong_pd and txd_weak_pd are 0, and rxd_out is 1 (released). The block stays in Unpowered while supply_ok is 0.
- R2: In Unpowered with supply_ok high, the block moves to Fail-safe on the next clock edge. Fail-safe with no pending wake drives inh_on=1, tx_path_en=0, rx_path_en=0 and rxd_out=1.
- R3: supply_ok low at a clock edge forces Unpowered on that edge from any mode and clears both wake flags. After the supply returns, Fail-safe shows no wake.
- R4: In Fail-safe, the block enters Normal once the synchronized enable has been high for EN_DELAY_US ticks, on clock edge 2+EN_DELAY_US after the pin rises (tick every cycle). An enable pulse shorter than this leaves the mode unchanged.
- R5: In Normal, inh_on=1, tx_path_en=1, rx_path_en=1 and rxd_out equals rx_bus.
- R6: Sleep is entered only from Normal, on a falling edge of the synchronized enable while txd_in is 1, once the enable has stayed low for EN_DELAY_US ticks. This happens on clock edge 3+EN_DELAY_US after the pin falls (tick every cycle). Enable returning high earlier cancels the request. A falling edge while txd_in is 0 leaves the block in Normal.
- R7: In Sleep, inh_on=0, both path enables are 0 and rxd_out=1. Sleep is entered whatever the level of rx_bus.
- R8: In Sleep, a bus_wake or local_wake pulse moves the block to Fail-safe on the next edge with rxd_out=0. A local wake sets txd_strong_pd=1. A bus-only wake sets txd_weak_pd=1. When both arrive together, the local source wins.
- R9: Both wake flags clear on the third clock edge after the enable pin rises. This is before Normal is reached, and it happens even for an enable pulse too short to change mode.
- R10: Debounce delays advance only on cycles where us_tick is 1. Clock cycles without a tick do not shorten the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above undervoltage threshold |
| en_pin | input | 1 | Asynchronous mode enable from the host |
| txd_in | input | 1 | Transmit-data level from the host |
| rx_bus | input | 1 | Received bus level (1 = recessive) |
| bus_wake | input | 1 | Filtered remote wake pulse |
| local_wake | input | 1 | Filtered local wake pulse |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| inh_on | output | 1 | Regulator-inhibit switch on |
| tx_path_en | output | 1 | Transmit path enabled |
| rx_path_en | output | 1 | Receive path enabled |
| rxd_out | output | 1 | Receive-data output level |
| txd_strong_pd | output | 1 | Strong pull-down on TXD (local wake) |
| txd_weak_pd | output | 1 | Weak pull-down on TXD (bus wake) |

## Verification
The bench builds the block with EN_DELAY_US=3. This makes every debounce window a few cycles long, so each mode transition can be checked on the exact edge one cycle before and on the edge it happens. The tick is driven every cycle for the exact-edge checks and every third cycle for the tick-gating checks. The bench walks each mode transition in turn and each wake-source combination. It also covers enable pulses shorter than the delay in both directions, and a supply drop from each mode.

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int EN_DELAY_US = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic en_pin,
  input  logic txd_in,
  input  logic rx_bus,
  input  logic bus_wake,
  input  logic local_wake,
  input  logic us_tick,
  output logic inh_on,
  output logic tx_path_en,
  output logic rx_path_en,
  output logic rxd_out,
  output logic txd_strong_pd,
  output logic txd_weak_pd
);

  localparam int CW = (EN_DELAY_US > 1) ? $clog2(EN_DELAY_US) : 1;

  typedef enum logic [1:0] {M_OFF, M_SAFE, M_RUN, M_DOZE} mode_t;

  mode_t         mode;
  logic          en_s1, en_s2, en_q;
  logic          sleep_arm, wake_flag, wake_local;
  logic [CW-1:0] dly;

  wire en_fall  = en_q & ~en_s2;
  wire dly_done = us_tick && (dly == CW'(EN_DELAY_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1 <= 1'b0;
      en_s2 <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_s1 <= en_pin;
      en_s2 <= en_s1;
      en_q  <= en_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_OFF;
      dly        <= '0;
      sleep_arm  <= 1'b0;
      wake_flag  <= 1'b0;
      wake_local <= 1'b0;
    end else if (!supply_ok) begin
      mode       <= M_OFF;
      dly        <= '0;
      sleep_arm  <= 1'b0;
      wake_flag  <= 1'b0;
      wake_local <= 1'b0;
    end else begin
      case (mode)
        M_OFF: mode <= M_SAFE;
        M_SAFE: begin
          if (en_s2) begin
            wake_flag  <= 1'b0;
            wake_local <= 1'b0;
            if (dly_done) begin
              mode <= M_RUN;
              dly  <= '0;
            end else if (us_tick) begin
              dly <= dly + 1'b1;
            end
          end else begin
            dly <= '0;
          end
        end
        M_RUN: begin
          if (sleep_arm) begin
            if (en_s2) begin
              sleep_arm <= 1'b0;
              dly       <= '0;
            end else if (dly_done) begin
              mode      <= M_DOZE;
              sleep_arm <= 1'b0;
              dly       <= '0;
            end else if (us_tick) begin
              dly <= dly + 1'b1;
            end
          end else if (en_fall && txd_in) begin
            sleep_arm <= 1'b1;
            dly       <= '0;
          end
        end
        M_DOZE: begin
          if (bus_wake || local_wake) begin
            mode       <= M_SAFE;
            wake_flag  <= 1'b1;
            wake_local <= local_wake;
          end
        end
        default: mode <= M_OFF;
      endcase
    end
  end

  assign inh_on        = (mode == M_SAFE) || (mode == M_RUN);
  assign tx_path_en    = (mode == M_RUN);
  assign rx_path_en    = (mode == M_RUN);
  assign rxd_out       = (mode == M_RUN)  ? rx_bus :
                         (mode == M_SAFE) ? ~wake_flag : 1'b1;
  assign txd_strong_pd = (mode == M_SAFE) && wake_flag && wake_local;
  assign txd_weak_pd   = (mode == M_SAFE) && wake_flag && !wake_local;

  a_r2_powerup_to_safe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_OFF && mode != M_OFF) |-> mode == M_SAFE);

  a_r3_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (mode == M_OFF && !wake_flag));

  a_r4_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && $past(mode) != M_RUN) |-> ($past(mode) == M_SAFE && $past(en_s2)));

  a_r6_doze_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DOZE && $past(mode) != M_DOZE) |->
      ($past(mode) == M_RUN && !$past(en_s2) && $past(sleep_arm)));

  a_r8_wake_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> ($past(mode) == M_DOZE && mode == M_SAFE));

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SAFE && en_s2 && supply_ok) |=> !wake_flag);

endmodule

// File: tb/lin_mode_ctrl_bench.sv
module lin_mode_ctrl_bench;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n, supply_ok, en_pin, txd_in, rx_bus, bus_wake, local_wake;
  logic us_tick = 1'b1;
  logic inh_on, tx_path_en, rx_path_en, rxd_out, txd_strong_pd, txd_weak_pd;

  int errors = 0;
  int checks = 0;
  int tick_per = 1;
  int tcnt = 0;
  bit done = 1'b0;

  localparam logic [5:0] O_OFF   = 6'b000100;
  localparam logic [5:0] O_SAFE  = 6'b100100;
  localparam logic [5:0] O_LOCAL = 6'b100010;
  localparam logic [5:0] O_BUS   = 6'b100001;
  localparam logic [5:0] O_DOZE  = 6'b000100;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tcnt = (tcnt + 1 >= tick_per) ? 0 : tcnt + 1;
    us_tick = (tcnt == 0);
  end

  lin_mode_ctrl #(.EN_DELAY_US(D)) u_lin_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(en_pin),
    .txd_in(txd_in), .rx_bus(rx_bus), .bus_wake(bus_wake),
    .local_wake(local_wake), .us_tick(us_tick), .inh_on(inh_on),
    .tx_path_en(tx_path_en), .rx_path_en(rx_path_en), .rxd_out(rxd_out),
    .txd_strong_pd(txd_strong_pd), .txd_weak_pd(txd_weak_pd));

  function automatic logic [5:0] o_run(input logic b);
    return {3'b111, b, 2'b00};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] got;
    got = {inh_on, tx_path_en, rx_path_en, rxd_out, txd_strong_pd, txd_weak_pd};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic go_run();
    en_pin = 1'b1;
    wait_n(D + 2);
  endtask

  task automatic go_doze();
    txd_in = 1'b1;
    en_pin = 1'b0;
    wait_n(D + 3);
  endtask

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; en_pin = 1'b0; txd_in = 1'b1;
    rx_bus = 1'b1; bus_wake = 1'b0; local_wake = 1'b0;
    wait_n(2);
    check("R1 reset state", O_OFF);
    rst_n = 1'b1;
    wait_n(3);
    check("R1 stays unpowered without supply", O_OFF);

    supply_ok = 1'b1;
    wait_n(1);
    check("R2 power-up to fail-safe", O_SAFE);

    en_pin = 1'b1; wait_n(1); en_pin = 1'b0;
    wait_n(10);
    check("R4 short enable pulse keeps fail-safe", O_SAFE);

    en_pin = 1'b1;
    wait_n(D + 1);
    check("R4 one edge before normal", O_SAFE);
    wait_n(1);
    check("R4 normal reached on edge 2+D", o_run(1'b1));
    for (int b = 0; b < 2; b++) begin
      rx_bus = b[0];
      #1;
      check("R5 rxd follows bus", o_run(b[0]));
    end
    rx_bus = 1'b1;

    txd_in = 1'b0; en_pin = 1'b0;
    wait_n(12);
    check("R6 fall with txd low stays normal", o_run(1'b1));
    txd_in = 1'b1;
    wait_n(4);
    check("R6 later txd high without edge stays normal", o_run(1'b1));
    en_pin = 1'b1; wait_n(4);
    en_pin = 1'b0; wait_n(1); en_pin = 1'b1;
    wait_n(12);
    check("R6 short low pulse cancels sleep", o_run(1'b1));

    rx_bus = 1'b0; en_pin = 1'b0;
    wait_n(D + 2);
    check("R6 one edge before sleep", o_run(1'b0));
    wait_n(1);
    check("R7 sleep entered with dominant bus", O_DOZE);
    en_pin = 1'b1; wait_n(8); en_pin = 1'b0; wait_n(4);
    check("R7 enable ignored in sleep", O_DOZE);
    rx_bus = 1'b1;

    bus_wake = 1'b1; wait_n(1); bus_wake = 1'b0;
    check("R8 bus wake weak pull-down", O_BUS);
    wait_n(5);
    check("R8 bus wake flag held", O_BUS);

    en_pin = 1'b1;
    wait_n(2);
    check("R9 flags still set after two edges", O_BUS);
    wait_n(1);
    check("R9 flags cleared on third edge", O_SAFE);
    wait_n(D - 1);
    check("R4 normal after wake clear", o_run(1'b1));

    go_doze();
    check("R6 sleep again", O_DOZE);
    local_wake = 1'b1; wait_n(1); local_wake = 1'b0;
    check("R8 local wake strong pull-down", O_LOCAL);
    supply_ok = 1'b0; wait_n(1);
    check("R3 supply loss from fail-safe", O_OFF);
    supply_ok = 1'b1; wait_n(1);
    check("R3 flags cleared after supply return", O_SAFE);

    go_run();
    check("R4 normal again", o_run(1'b1));
    go_doze();
    bus_wake = 1'b1; local_wake = 1'b1; wait_n(1);
    bus_wake = 1'b0; local_wake = 1'b0;
    check("R8 both wakes local wins", O_LOCAL);

    en_pin = 1'b1; wait_n(1); en_pin = 1'b0;
    wait_n(6);
    check("R9 short pulse clears flags", O_SAFE);

    go_run();
    supply_ok = 1'b0; wait_n(1);
    check("R3 supply loss from normal", O_OFF);
    supply_ok = 1'b1; wait_n(1);
    go_run(); go_doze();
    check("R7 sleep before supply loss", O_DOZE);
    supply_ok = 1'b0; wait_n(1);
    check("R3 supply loss from sleep", O_OFF);

    tick_per = 3;
    supply_ok = 1'b1; wait_n(1);
    en_pin = 1'b1;
    wait_n(D + 2);
    check("R10 sparse ticks delay normal", O_SAFE);
    wait_n(3 * D + 6);
    check("R10 normal after enough ticks", o_run(1'b1));
    tick_per = 1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: outputs=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule